// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block corrects the colour of three independent RGB pixel streams with per-channel lookup tables. Every channel owns three tables of 256 eight-bit entries, one per colour component. Each incoming pixel has its red, green and blue values replaced by the entries they index in that channel's tables. The result appears one register stage later. A per-channel enable chooses between the corrected pixel and the untouched input.

All nine tables share one flat address space. Channel n starts at n*768. Inside a channel the red table comes first, then green, then blue. Software fills the tables through two plain ports. An address load sets the write pointer and the auto-increment flag. A data strobe writes one entry. When auto-increment is on, the pointer advances by one after each data write, so a whole channel, or all channels, can be loaded with one address load followed by a burst of data writes. The storage is nine independent 256-entry banks, so the pixel lookups never compete with each other. They only compete with a CPU write that lands in the bank they need in that same cycle.

Each pixel channel is a valid/ready stream with one output register. A pixel is accepted when `px_in_valid` and `px_in_ready` are both high on a clock edge. `px_in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `px_out_valid` is high and `px_out_ready` is low, the output pixel and its valid stay frozen, and the channel accepts nothing. When no channel has gamma enabled, the table storage counts as powered down. Its contents are lost and are replaced by the identity mapping, so the tables must be reloaded after gamma is switched back on.

Top module: `gamma_lut_multi`

## Requirements
- R1: After reset every `px_out_valid` bit is 0, every `px_in_ready` bit is 1, and every table holds the identity mapping (entry i = i).
- R2: Table entry address = channel*768 + component*256 + index, with component 0 = red, 1 = green, 2 = blue. A pixel is packed with red in bits [23:16], green in [15:8] and blue in [7:0] of its channel's 24-bit slice (channel n at bits [24n+23:24n]).
- R3: An address load (`cfg_addr_we`) sets the write pointer to `cfg_addr` and latches `cfg_autoinc`. Each data write (`cfg_data_we`) stores `cfg_data` at the pointer. With the flag set the pointer then advances by one; with it clear the pointer holds, so repeated writes overwrite the same entry.
- R4: Auto-increment wraps from the last entry (2303) back to address 0.
- R5: A pixel accepted while its channel's `gamma_en` bit is 1 leaves with each component replaced by that channel's table entry. A pixel accepted while the bit is 0 leaves equal to its input.
- R6: An accepted pixel is presented on `px_out_valid` and `px_out_pixel` in the next cycle. `px_in_ready` equals NOT `px_out_valid` OR `px_out_ready`. While stalled, the output holds its value and valid.
- R7: A CPU write to a table in the same cycle that a pixel of that channel is accepted takes priority. That component of the output repeats the value the same table last produced, while the other components are looked up normally. The write itself is kept.
- R8: While all `gamma_en` bits are 0, every table returns to the identity mapping and data writes are discarded. The pointer still advances as in R3.
- R9: A data write at a pointer of 2304 or above changes no table.
- R10: Writes to one channel's tables do not alter the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_we | input | 1 | Load write pointer and auto-increment flag |
| cfg_addr | input | 12 | Write pointer value |
| cfg_autoinc | input | 1 | Auto-increment flag loaded with the pointer |
| cfg_data_we | input | 1 | Write one table entry at the pointer |
| cfg_data | input | 8 | Table entry value |
| gamma_en | input | 3 | Per-channel gamma enable |
| px_in_valid | input | 3 | Input pixel valid, one bit per channel |
| px_in_ready | output | 3 | Input pixel ready, one bit per channel |
| px_in_pixel | input | 72 | Input pixels, 24 bits per channel |
| px_out_valid | output | 3 | Output pixel valid, one bit per channel |
| px_out_ready | input | 3 | Output pixel ready, one bit per channel |
| px_out_pixel | output | 72 | Output pixels, 24 bits per channel |

## Verification
The bench drives a write to the green table in the same cycle that a channel-0 pixel is accepted. A design that let the pixel read win, or that stalled the write, would return a fresh green value or lose the entry. It walks the pointer across the top of the address space. A design without the wrap would fill the next table at address 2304 and leave entry 0 untouched. It also writes at an out-of-range pointer, which a truncating bank decode would alias onto channel 0. Other cases are a stall of several cycles, which a design that reloads its output register would corrupt, and a full power-down. A design that kept its tables, or accepted writes while powered down, would return corrected values where the identity is due.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  // component width and table depth
  localparam int unsigned COMP_W = 8;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned NCOMP  = 3;
  localparam int unsigned PIX_W  = COMP_W * NCOMP;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  // bit offset of a component inside a packed pixel (red on top)
  function automatic int unsigned comp_lsb(input int unsigned c);
    return (NCOMP - 1 - c) * COMP_W;
  endfunction
endpackage

// File: rtl/gamma_cfg_port.sv
module gamma_cfg_port
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned NBANK = NCH * NCOMP,
  localparam int unsigned TOTAL = NBANK * DEPTH,
  localparam int unsigned AW    = $clog2(TOTAL),
  localparam int unsigned SW    = AW - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              addr_we,
  input  logic [AW-1:0]     addr_in,
  input  logic              autoinc_in,
  input  logic              data_we,
  input  logic [COMP_W-1:0] data_in,
  output logic [NBANK-1:0]  bank_we,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [COMP_W-1:0] bank_data
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0] ptr_q;
  logic          auto_q;
  logic [SW-1:0] sel;
  logic          we_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
    end else if (addr_we) begin
      ptr_q  <= addr_in;
      auto_q <= autoinc_in;
    end else if (data_we && auto_q) begin
      ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign sel       = ptr_q[AW-1:IDX_W];
  assign bank_idx  = ptr_q[IDX_W-1:0];
  assign bank_data = data_in;
  assign we_ok     = data_we && !pwr_down;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign bank_we[b] = we_ok && (sel == SW'(b));
  end

  // R3
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && auto_q && ptr_q < LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && !auto_q) |=> $stable(ptr_q));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && auto_q && ptr_q == LAST) |=> ptr_q == '0);
  // R9
  bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  // R8
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> bank_we == '0);
endmodule

// File: rtl/gamma_bank.sv
module gamma_bank
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [COMP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COMP_W-1:0] rd_data
);
  logic [COMP_W-1:0] mem [DEPTH];

  // storage: identity after reset and after power-down
  always_ff @(posedge clk) begin
    if (!rst_n || pwr_down) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= COMP_W'(i);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // read register: a colliding write wins, the old value stays
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en && !wr_en) begin
      rd_data <= mem[rd_idx];
    end
  end

  // R7
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> $stable(rd_data));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              gamma_on,
  input  logic [NCOMP-1:0]  tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [COMP_W-1:0] tbl_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pixel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel
);
  logic             load;
  logic             vld_q;
  logic             on_q;
  logic [PIX_W-1:0] raw_q;
  logic [PIX_W-1:0] mapped;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    localparam int unsigned LSB = comp_lsb(c);
    logic [COMP_W-1:0] rd;
    gamma_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_down(pwr_down),
      .wr_en   (tbl_we[c]),
      .wr_idx  (tbl_idx),
      .wr_data (tbl_data),
      .rd_en   (load),
      .rd_idx  (in_pixel[LSB +: COMP_W]),
      .rd_data (rd)
    );
    assign mapped[LSB +: COMP_W] = rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      on_q  <= 1'b0;
      raw_q <= '0;
    end else begin
      if (load) begin
        vld_q <= 1'b1;
        on_q  <= gamma_on;
        raw_q <= in_pixel;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_pixel = on_q ? mapped : raw_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));
  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !gamma_on) |=> out_pixel == $past(in_pixel));
endmodule

// File: rtl/gamma_lut_multi.sv
module gamma_lut_multi
  import gamma_lut_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned NBANK = NCH * NCOMP,
  localparam int unsigned AW    = $clog2(NBANK * DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_addr_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic                 cfg_autoinc,
  input  logic                 cfg_data_we,
  input  logic [COMP_W-1:0]    cfg_data,
  input  logic [NCH-1:0]       gamma_en,
  input  logic [NCH-1:0]       px_in_valid,
  output logic [NCH-1:0]       px_in_ready,
  input  logic [NCH*PIX_W-1:0] px_in_pixel,
  output logic [NCH-1:0]       px_out_valid,
  input  logic [NCH-1:0]       px_out_ready,
  output logic [NCH*PIX_W-1:0] px_out_pixel
);
  logic              pwr_down;
  logic [NBANK-1:0]  bank_we;
  logic [IDX_W-1:0]  bank_idx;
  logic [COMP_W-1:0] bank_data;

  assign pwr_down = ~|gamma_en;

  gamma_cfg_port #(.NCH(NCH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .addr_we   (cfg_addr_we),
    .addr_in   (cfg_addr),
    .autoinc_in(cfg_autoinc),
    .data_we   (cfg_data_we),
    .data_in   (cfg_data),
    .bank_we   (bank_we),
    .bank_idx  (bank_idx),
    .bank_data (bank_data)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    gamma_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .gamma_on (gamma_en[ch]),
      .tbl_we   (bank_we[ch*NCOMP +: NCOMP]),
      .tbl_idx  (bank_idx),
      .tbl_data (bank_data),
      .in_valid (px_in_valid[ch]),
      .in_ready (px_in_ready[ch]),
      .in_pixel (px_in_pixel[ch*PIX_W +: PIX_W]),
      .out_valid(px_out_valid[ch]),
      .out_ready(px_out_ready[ch]),
      .out_pixel(px_out_pixel[ch*PIX_W +: PIX_W])
    );
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> px_out_valid == '0);
endmodule

// File: tb/test_gamma_lut_multi.sv
module test_gamma_lut_multi;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NCH = 3;
  localparam int  TOTAL = NCH * 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_addr_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic        cfg_autoinc = 1'b0;
  logic        cfg_data_we = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic [2:0]  gamma_en = '0;
  logic [2:0]  px_in_valid = '0;
  logic [2:0]  px_in_ready;
  logic [71:0] px_in_pixel = '0;
  logic [2:0]  px_out_valid;
  logic [2:0]  px_out_ready = 3'b111;
  logic [71:0] px_out_pixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut_multi i_gamma_lut_multi (.*);

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] model [TOTAL];
  int  b_addr = 0;
  bit  b_auto = 0;

  // stimulus table: {channel, pixel}
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 24'h00_80_FF}, {2'd1, 24'h12_34_56}, {2'd2, 24'hFF_00_7F},
    {2'd0, 24'hA5_5A_01}, {2'd1, 24'hFE_FD_FC}, {2'd2, 24'h10_20_30},
    {2'd0, 24'h7F_80_81}, {2'd1, 24'h00_00_00}
  };

  function automatic logic [23:0] lookup(input int ch, input logic [23:0] p);
    return {model[ch*768 + p[23:16]], model[ch*768 + 256 + p[15:8]],
            model[ch*768 + 512 + p[7:0]]};
  endfunction

  function automatic logic [7:0] fill(input int k);
    return 8'((k * 37) + (k / 256) * 11 + 5);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_addr(input int a, input bit au);
    cfg_addr_we = 1'b1; cfg_addr = 12'(a); cfg_autoinc = au;
    @(negedge clk);
    cfg_addr_we = 1'b0;
    b_addr = a; b_auto = au;
  endtask

  task automatic put_data(input logic [7:0] v);
    cfg_data_we = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_data_we = 1'b0;
    if (|gamma_en && b_addr < TOTAL) model[b_addr] = v;
    if (b_auto) b_addr = (b_addr >= TOTAL - 1) ? 0 : b_addr + 1;
  endtask

  task automatic send(input string req, input int ch, input logic [23:0] p);
    logic [23:0] exp;
    exp = gamma_en[ch] ? lookup(ch, p) : p;
    px_in_valid[ch] = 1'b1; px_in_pixel[ch*24 +: 24] = p;
    @(negedge clk);
    px_in_valid[ch] = 1'b0;
    check(req, {31'd0, px_out_valid[ch]}, 32'd1);
    check(req, {8'd0, px_out_pixel[ch*24 +: 24]}, {8'd0, exp});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] prev_exp;
    logic [7:0]  prev_g;
    for (int k = 0; k < TOTAL; k++) model[k] = 8'(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs and identity tables
    check("R1", {29'd0, px_out_valid}, 32'd0);
    check("R1", {29'd0, px_in_ready}, 32'd7);
    gamma_en = 3'b111;
    send("R1", 0, 24'h12_34_56);

    // R2 R3: load all tables in one burst
    set_addr(0, 1'b1);
    for (int k = 0; k < TOTAL; k++) put_data(fill(k));

    // R5 R10: table walk
    for (int i = 0; i < 8; i++) send("R5", int'(VEC[i][25:24]), VEC[i][23:0]);

    // R5: bypass on channel 1 only
    gamma_en = 3'b101;
    send("R5", 1, 24'h12_34_56);
    send("R10", 0, 24'h12_34_56);
    gamma_en = 3'b111;

    // R3: no auto-increment, same entry overwritten
    set_addr(12'h010, 1'b0);
    put_data(8'hAA);
    put_data(8'hBB);
    send("R3", 0, 24'h10_00_00);
    send("R3", 0, 24'h11_00_00);

    // R4: wrap from 2303 to 0
    set_addr(TOTAL - 1, 1'b1);
    put_data(8'hC1);
    put_data(8'hC2);
    send("R4", 2, 24'h00_00_FF);
    send("R4", 0, 24'h00_00_00);

    // R9: out-of-range pointer changes nothing
    set_addr(12'h900, 1'b0);
    put_data(8'h77);
    send("R9", 0, 24'h00_00_00);
    send("R9", 2, 24'h00_00_00);

    // R7: write to channel-0 green table collides with a pixel
    set_addr(12'h140, 1'b0);
    send("R7", 0, 24'h11_22_33);
    prev_g = model[256 + 8'h22];
    prev_exp = {model[8'h44], prev_g, model[512 + 8'h55]};
    px_in_valid[0] = 1'b1; px_in_pixel[23:0] = 24'h44_40_55;
    cfg_data_we = 1'b1; cfg_data = 8'h99;
    @(negedge clk);
    px_in_valid[0] = 1'b0; cfg_data_we = 1'b0;
    model[12'h140] = 8'h99;
    check("R7", {8'd0, px_out_pixel[23:0]}, {8'd0, prev_exp});
    send("R7", 0, 24'h00_40_00);

    // R6: back-pressure on channel 2
    px_out_ready[2] = 1'b0;
    px_in_valid[2] = 1'b1; px_in_pixel[71:48] = 24'h01_02_03;
    prev_exp = lookup(2, 24'h01_02_03);
    @(negedge clk);
    px_in_pixel[71:48] = 24'hF0_E0_D0;
    check("R6", {31'd0, px_out_valid[2]}, 32'd1);
    check("R6", {8'd0, px_out_pixel[71:48]}, {8'd0, prev_exp});
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R6", {31'd0, px_in_ready[2]}, 32'd0);
      check("R6", {8'd0, px_out_pixel[71:48]}, {8'd0, prev_exp});
    end
    px_out_ready[2] = 1'b1;
    @(negedge clk);
    px_in_valid[2] = 1'b0;
    check("R6", {31'd0, px_out_valid[2]}, 32'd1);
    check("R6", {8'd0, px_out_pixel[71:48]}, {8'd0, lookup(2, 24'hF0_E0_D0)});
    @(negedge clk);
    check("R6", {31'd0, px_out_valid[2]}, 32'd0);

    // R8: power down, writes dropped, identity afterwards
    gamma_en = 3'b000;
    @(negedge clk);
    for (int k = 0; k < TOTAL; k++) model[k] = 8'(k);
    set_addr(0, 1'b1);
    put_data(8'h55);
    gamma_en = 3'b001;
    send("R8", 0, 24'h00_40_80);
    put_data(8'hE7);
    send("R8", 0, 24'h01_00_00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule